// File: doc/BRIEF.md
# SDRAM Write Burst Engine

This block is the device-side write path of a four-bank SDRAM with a 32-bit data bus. It decodes the command pins on each rising clock edge. A WRITE command captures the bank, the starting column and the auto-precharge flag. From then on the block produces one storage-array write beat per clock, with the column address, the data word and per-byte write enables. The array is organised as one array per bank.

The first data word is taken on the same edge that registers the WRITE. Later words follow on successive edges. A fixed-length burst ends by itself after its programmed length. A full-page burst runs until a command stops it, and its column wraps at the end of the page. A later WRITE, READ, BURST TERMINATE or PRECHARGE can cut a burst short on any cycle, and each of these has its own rule for the data word that arrives with it. When auto precharge was requested and a fixed burst runs to completion, the block issues a precharge request for that bank.

Each write beat and each precharge request is registered and appears on the output ports just after the clock edge that takes it.

Top module: `sdram_wr_engine`

## Requirements
- R1: A WRITE command ({cs_n,ras_n,cas_n,we_n}=0100) writes its own data word in the same edge that registers it. The word goes to bank `ba` and column `addr`, with byte enables equal to the inverse of `dqm`. After that edge, `wr_vld`=1 and the other write fields show this beat.
- R2: Each following edge writes the next word at the next column. Counting is sequential and wraps inside the block aligned to the burst length L. `bl_mode` values 0, 1, 2 and 3 select L = 1, 2, 4 and 8.
- R3: A fixed burst writes exactly L beats. After that, no write occurs (`wr_vld`=0) while NOP commands arrive with changing data.
- R4: With `bl_mode` 4 to 7 (full page), the burst continues without limit and the column steps from 255 to 0.
- R5: A WRITE that arrives during a burst ends the old burst. It writes its own data to its own bank and column, then continues as a new burst.
- R6: A READ (0101) during a burst ends it. The data in that cycle and in later cycles is not written.
- R7: A BURST TERMINATE (0110) during a burst ends it. The word presented with it is discarded. The last word written is the one from the previous cycle.
- R8: A PRECHARGE (0010) during a burst ends it, and the word presented with it is not written.
- R9: A high `dqm` bit clears the byte enable of its own lane for that beat only. The column still advances.
- R10: When `ap_flag` is high on the WRITE and the fixed burst completes, `pre_vld`=1 with `pre_bank`=the burst's bank, appearing together with the last beat. If the burst is cut short, no request is issued.
- R11: After reset, `wr_vld` and `pre_vld` are 0.
- R12: A deselect (cs_n=1) or any command not listed above acts as NOP, so a burst in progress continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command pin |
| cas_n | input | 1 | Column strobe command pin |
| we_n | input | 1 | Write enable command pin |
| ba | input | 2 | Bank address |
| addr | input | 8 | Starting column address |
| ap_flag | input | 1 | Auto-precharge request sampled with WRITE |
| dq | input | 32 | Write data |
| dqm | input | 4 | Per-byte input mask, high masks |
| bl_mode | input | 3 | Burst length select |
| wr_vld | output | 1 | A write beat was taken at the last edge |
| wr_bank | output | 2 | Bank of the beat |
| wr_col | output | 8 | Column of the beat |
| wr_data | output | 32 | Data of the beat |
| wr_be | output | 4 | Byte enables of the beat |
| pre_vld | output | 1 | Auto-precharge request |
| pre_bank | output | 2 | Bank to precharge |

## Verification
Every result, whether a beat, a non-write or a precharge request, appears on the ports one register stage after the rising edge where its command and data are sampled. The bench drives each command and data word at the falling edge. It then reads the outputs at the next falling edge, so each check sees exactly the edge that took that stimulus. Terminating commands are checked in the cycle they arrive and again on following NOP cycles, which confirms that no stray beat or precharge follows.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;
  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_WRITE,
    CMD_READ,
    CMD_BST,
    CMD_PRE,
    CMD_OTHER
  } cmd_e;

  localparam int unsigned BL_SEL_W = 3;
  localparam int unsigned FIX_CNT_W = 3;
endpackage

// File: rtl/sdram_wr_cmd_dec.sv
module sdram_wr_cmd_dec
  import sdram_wr_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) begin
      cmd = CMD_NOP;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b100:  cmd = CMD_WRITE;
        3'b101:  cmd = CMD_READ;
        3'b110:  cmd = CMD_BST;
        3'b010:  cmd = CMD_PRE;
        default: cmd = CMD_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/sdram_wr_burst_ctrl.sv
module sdram_wr_burst_ctrl
  import sdram_wr_pkg::*;
#(
  parameter int unsigned COL_W  = 8,
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  input  logic [BANK_W-1:0] ba,
  input  logic [COL_W-1:0]  col_in,
  input  logic              ap_in,
  input  logic [BL_SEL_W-1:0] bl_sel,
  output logic              beat_en,
  output logic [BANK_W-1:0] beat_bank,
  output logic [COL_W-1:0]  beat_col,
  output logic              beat_pre
);
  localparam int unsigned CNT_W = FIX_CNT_W;

  logic              active_q, active_d;
  logic              full_q, full_d;
  logic              ap_q, ap_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic [COL_W-1:0]  mask_q, mask_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [COL_W-1:0]  new_mask;
  logic              stop_cmd;

  function automatic logic [COL_W-1:0] step_col(input logic [COL_W-1:0] c,
                                                input logic [COL_W-1:0] m);
    return (c & ~m) | ((c + COL_W'(1)) & m);
  endfunction

  assign new_mask = bl_sel[2] ? {COL_W{1'b1}}
                              : COL_W'((COL_W'(1) << bl_sel[1:0]) - COL_W'(1));
  assign stop_cmd = (cmd == CMD_READ) || (cmd == CMD_BST) || (cmd == CMD_PRE);

  always_comb begin
    active_d  = active_q;
    full_d    = full_q;
    ap_d      = ap_q;
    bank_d    = bank_q;
    col_d     = col_q;
    mask_d    = mask_q;
    left_d    = left_q;
    beat_en   = 1'b0;
    beat_bank = bank_q;
    beat_col  = col_q;
    beat_pre  = 1'b0;
    if (cmd == CMD_WRITE) begin
      beat_en   = 1'b1;
      beat_bank = ba;
      beat_col  = col_in;
      active_d  = (bl_sel != '0);
      full_d    = bl_sel[2];
      ap_d      = ap_in;
      bank_d    = ba;
      mask_d    = new_mask;
      col_d     = step_col(col_in, new_mask);
      left_d    = new_mask[CNT_W-1:0];
      beat_pre  = (bl_sel == '0) && ap_in;
    end else if (active_q) begin
      if (stop_cmd) begin
        active_d = 1'b0;
      end else begin
        beat_en = 1'b1;
        col_d   = step_col(col_q, mask_q);
        if (!full_q) begin
          left_d = left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) begin
            active_d = 1'b0;
            beat_pre = ap_q;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      ap_q     <= 1'b0;
      bank_q   <= '0;
      col_q    <= '0;
      mask_q   <= '0;
      left_q   <= '0;
    end else begin
      active_q <= active_d;
      full_q   <= full_d;
      ap_q     <= ap_d;
      bank_q   <= bank_d;
      col_q    <= col_d;
      mask_q   <= mask_d;
      left_q   <= left_d;
    end
  end

  // R4: full-page column rolls from the last column to zero
  p_page_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && full_q && (col_q == {COL_W{1'b1}}) &&
     (cmd != CMD_WRITE) && !stop_cmd) |=> (col_q == '0));

  // R3: a fixed burst never runs with zero beats left
  p_fixed_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !full_q) |-> (left_q != '0));
endmodule

// File: rtl/sdram_wr_beat_reg.sv
module sdram_wr_beat_reg #(
  parameter int unsigned COL_W  = 8,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_en,
  input  logic [BANK_W-1:0] beat_bank,
  input  logic [COL_W-1:0]  beat_col,
  input  logic [DATA_W-1:0] beat_data,
  input  logic [BE_W-1:0]   beat_mask,
  input  logic              beat_pre,
  output logic              wr_vld,
  output logic [BANK_W-1:0] wr_bank,
  output logic [COL_W-1:0]  wr_col,
  output logic [DATA_W-1:0] wr_data,
  output logic [BE_W-1:0]   wr_be,
  output logic              pre_vld,
  output logic [BANK_W-1:0] pre_bank
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_vld  <= 1'b0;
      pre_vld <= 1'b0;
    end else begin
      wr_vld  <= beat_en;
      pre_vld <= beat_pre;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bank <= '0;
      wr_col  <= '0;
      wr_data <= '0;
      wr_be   <= '0;
    end else if (beat_en) begin
      wr_bank <= beat_bank;
      wr_col  <= beat_col;
      wr_data <= beat_data;
      wr_be   <= ~beat_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_bank <= '0;
    end else if (beat_pre) begin
      pre_bank <= beat_bank;
    end
  end
endmodule

// File: rtl/sdram_wr_engine.sv
module sdram_wr_engine
  import sdram_wr_pkg::*;
#(
  parameter int unsigned COL_W  = 8,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba,
  input  logic [COL_W-1:0]  addr,
  input  logic              ap_flag,
  input  logic [DATA_W-1:0] dq,
  input  logic [BE_W-1:0]   dqm,
  input  logic [BL_SEL_W-1:0] bl_mode,
  output logic              wr_vld,
  output logic [BANK_W-1:0] wr_bank,
  output logic [COL_W-1:0]  wr_col,
  output logic [DATA_W-1:0] wr_data,
  output logic [BE_W-1:0]   wr_be,
  output logic              pre_vld,
  output logic [BANK_W-1:0] pre_bank
);
  logic [1:0]        rst_pipe;
  logic              rst_i_n;
  cmd_e              cmd;
  logic              beat_en;
  logic [BANK_W-1:0] beat_bank;
  logic [COL_W-1:0]  beat_col;
  logic              beat_pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  sdram_wr_cmd_dec u_dec (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .cmd  (cmd)
  );

  sdram_wr_burst_ctrl #(.COL_W(COL_W), .BANK_W(BANK_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .cmd      (cmd),
    .ba       (ba),
    .col_in   (addr),
    .ap_in    (ap_flag),
    .bl_sel   (bl_mode),
    .beat_en  (beat_en),
    .beat_bank(beat_bank),
    .beat_col (beat_col),
    .beat_pre (beat_pre)
  );

  sdram_wr_beat_reg #(.COL_W(COL_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_beat (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .beat_en  (beat_en),
    .beat_bank(beat_bank),
    .beat_col (beat_col),
    .beat_data(dq),
    .beat_mask(dqm),
    .beat_pre (beat_pre),
    .wr_vld   (wr_vld),
    .wr_bank  (wr_bank),
    .wr_col   (wr_col),
    .wr_data  (wr_data),
    .wr_be    (wr_be),
    .pre_vld  (pre_vld),
    .pre_bank (pre_bank)
  );

  // R1: a WRITE produces its own beat right after the edge that takes it
  p_write_beat_r1: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd == CMD_WRITE) |=> (wr_vld && wr_col == $past(addr) &&
                            wr_bank == $past(ba) && wr_data == $past(dq)));

  // R6: READ takes no data
  p_read_blocks_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd == CMD_READ) |=> !wr_vld);

  // R7: BURST TERMINATE drops its own data word
  p_bst_drops_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd == CMD_BST) |=> !wr_vld);

  // R8: PRECHARGE drops its own data word
  p_pre_drops_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd == CMD_PRE) |=> !wr_vld);

  // R10: a precharge request accompanies a final beat
  p_pre_with_beat_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    pre_vld |-> wr_vld);
endmodule

// File: tb/sdram_wr_engine_tb.sv
`timescale 1ns/1ps
module sdram_wr_engine_tb_top;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_BST = 4'b0110;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_DES = 4'b1111;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [7:0]  addr;
  logic        ap_flag;
  logic [31:0] dq;
  logic [3:0]  dqm;
  logic [2:0]  bl_mode;
  logic        wr_vld;
  logic [1:0]  wr_bank;
  logic [7:0]  wr_col;
  logic [31:0] wr_data;
  logic [3:0]  wr_be;
  logic        pre_vld;
  logic [1:0]  pre_bank;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  sdram_wr_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .ap_flag(ap_flag), .dq(dq), .dqm(dqm),
    .bl_mode(bl_mode), .wr_vld(wr_vld), .wr_bank(wr_bank), .wr_col(wr_col),
    .wr_data(wr_data), .wr_be(wr_be), .pre_vld(pre_vld), .pre_bank(pre_bank)
  );

  task automatic drive(input logic [3:0] c, input logic [1:0] b, input logic [7:0] a,
                       input logic ap, input logic [31:0] d, input logic [3:0] m);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b; addr = a; ap_flag = ap; dq = d; dqm = m;
    @(negedge clk);
  endtask

  task automatic expect_beat(input string tag, input logic [1:0] b, input logic [7:0] c,
                             input logic [31:0] d, input logic [3:0] be,
                             input logic pre, input logic [1:0] pb);
    vectors++;
    if (!wr_vld || wr_bank != b || wr_col != c || wr_data != d || wr_be != be ||
        pre_vld != pre || (pre && pre_bank != pb)) begin
      fails++;
      $display("FAIL %s: got vld=%0b bank=%0d col=%h data=%h be=%b pre=%0b/%0d, exp vld=1 bank=%0d col=%h data=%h be=%b pre=%0b/%0d",
               tag, wr_vld, wr_bank, wr_col, wr_data, wr_be, pre_vld, pre_bank,
               b, c, d, be, pre, pb);
    end
  endtask

  task automatic expect_idle(input string tag);
    vectors++;
    if (wr_vld || pre_vld) begin
      fails++;
      $display("FAIL %s: got vld=%0b pre=%0b, exp vld=0 pre=0", tag, wr_vld, pre_vld);
    end
  endtask

  task automatic t_reset();
    expect_idle("R11 reset");
  endtask

  task automatic t_bl4_wrap();
    bl_mode = 3'd2;
    drive(C_WR, 2'd1, 8'h06, 1'b0, 32'hA000_0000, 4'h0);
    expect_beat("R1 first beat", 2'd1, 8'h06, 32'hA000_0000, 4'hF, 1'b0, 2'd0);
    drive(C_NOP, 2'd0, 8'h00, 1'b0, 32'hA000_0001, 4'h0);
    expect_beat("R2 beat2", 2'd1, 8'h07, 32'hA000_0001, 4'hF, 1'b0, 2'd0);
    drive(C_NOP, 2'd0, 8'h00, 1'b0, 32'hA000_0002, 4'h0);
    expect_beat("R2 wrap in block", 2'd1, 8'h04, 32'hA000_0002, 4'hF, 1'b0, 2'd0);
    drive(C_NOP, 2'd0, 8'h00, 1'b0, 32'hA000_0003, 4'h0);
    expect_beat("R2 beat4", 2'd1, 8'h05, 32'hA000_0003, 4'hF, 1'b0, 2'd0);
    drive(C_NOP, 2'd0, 8'h00, 1'b0, 32'hA000_0004, 4'h0);
    expect_idle("R3 done after 4");
    drive(C_NOP, 2'd0, 8'h00, 1'b0, 32'hA000_0005, 4'h0);
    expect_idle("R3 still idle");
  endtask

  task automatic t_bl8_autopre();
    bl_mode = 3'd3;
    drive(C_WR, 2'd2, 8'h10, 1'b1, 32'h0000_0100, 4'h0);
    expect_beat("R1 bl8 start", 2'd2, 8'h10, 32'h0000_0100, 4'hF, 1'b0, 2'd0);
    for (int i = 1; i < 8; i++) begin
      drive(C_NOP, 2'd0, 8'h00, 1'b0, 32'h0000_0100 + 32'(i), 4'h0);
      expect_beat(i == 7 ? "R10 last beat precharge" : "R2 bl8 beat", 2'd2,
                  8'h10 + 8'(i), 32'h0000_0100 + 32'(i), 4'hF, i == 7, 2'd2);
    end
    drive(C_NOP, 2'd0, 8'h00, 1'b0, 32'hDEAD_0000, 4'h0);
    expect_idle("R3 bl8 ended");
  endtask

  task automatic t_full_page();
    bl_mode = 3'd7;
    drive(C_WR, 2'd3, 8'hFE, 1'b0, 32'hF000_0000, 4'h0);
    expect_beat("R4 page start", 2'd3, 8'hFE, 32'hF000_0000, 4'hF, 1'b0, 2'd0);
    drive(C_NOP, 2'd0, 8'h00, 1'b0, 32'hF000_0001, 4'h0);
    expect_beat("R4 last col", 2'd3, 8'hFF, 32'hF000_0001, 4'hF, 1'b0, 2'd0);
    drive(C_NOP, 2'd0, 8'h00, 1'b0, 32'hF000_0002, 4'h0);
    expect_beat("R4 wrap to 0", 2'd3, 8'h00, 32'hF000_0002, 4'hF, 1'b0, 2'd0);
    drive(C_NOP, 2'd0, 8'h00, 1'b0, 32'hF000_0003, 4'h0);
    expect_beat("R4 col 1", 2'd3, 8'h01, 32'hF000_0003, 4'hF, 1'b0, 2'd0);
    drive(C_BST, 2'd0, 8'h00, 1'b0, 32'hBAD0_0000, 4'h0);
    expect_idle("R7 bst drops word");
    drive(C_NOP, 2'd0, 8'h00, 1'b0, 32'hBAD0_0001, 4'h0);
    expect_idle("R7 after bst");
  endtask

  task automatic t_write_interrupt();
    bl_mode = 3'd3;
    drive(C_WR, 2'd0, 8'h20, 1'b0, 32'h1111_0000, 4'h0);
    expect_beat("R5 old burst", 2'd0, 8'h20, 32'h1111_0000, 4'hF, 1'b0, 2'd0);
    drive(C_NOP, 2'd0, 8'h00, 1'b0, 32'h1111_0001, 4'h0);
    expect_beat("R5 old beat2", 2'd0, 8'h21, 32'h1111_0001, 4'hF, 1'b0, 2'd0);
    drive(C_WR, 2'd3, 8'h40, 1'b0, 32'h2222_0000, 4'h0);
    expect_beat("R5 new write", 2'd3, 8'h40, 32'h2222_0000, 4'hF, 1'b0, 2'd0);
    drive(C_NOP, 2'd0, 8'h00, 1'b0, 32'h2222_0001, 4'h0);
    expect_beat("R5 new beat2", 2'd3, 8'h41, 32'h2222_0001, 4'hF, 1'b0, 2'd0);
    drive(C_RD, 2'd3, 8'h00, 1'b0, 32'hBAD1_0000, 4'h0);
    expect_idle("R6 read stops");
    drive(C_NOP, 2'd0, 8'h00, 1'b0, 32'hBAD1_0001, 4'h0);
    expect_idle("R6 after read");
  endtask

  task automatic t_mask_precharge();
    bl_mode = 3'd2;
    drive(C_WR, 2'd0, 8'h08, 1'b0, 32'h3333_0000, 4'b0101);
    expect_beat("R9 masked lanes", 2'd0, 8'h08, 32'h3333_0000, 4'b1010, 1'b0, 2'd0);
    drive(C_NOP, 2'd0, 8'h00, 1'b0, 32'h3333_0001, 4'h0);
    expect_beat("R9 mask one beat only", 2'd0, 8'h09, 32'h3333_0001, 4'hF, 1'b0, 2'd0);
    drive(C_PRE, 2'd0, 8'h00, 1'b0, 32'hBAD2_0000, 4'h0);
    expect_idle("R8 precharge stops");
    drive(C_NOP, 2'd0, 8'h00, 1'b0, 32'hBAD2_0001, 4'h0);
    expect_idle("R8 after precharge");
  endtask

  task automatic t_autopre_cut();
    bl_mode = 3'd2;
    drive(C_WR, 2'd1, 8'h00, 1'b1, 32'h4444_0000, 4'h0);
    expect_beat("R10 ap start", 2'd1, 8'h00, 32'h4444_0000, 4'hF, 1'b0, 2'd0);
    drive(C_RD, 2'd1, 8'h00, 1'b0, 32'h4444_0001, 4'h0);
    expect_idle("R10 cut by read");
    for (int i = 0; i < 3; i++) begin
      drive(C_NOP, 2'd0, 8'h00, 1'b0, 32'h4444_0002, 4'h0);
      expect_idle("R10 no precharge after cut");
    end
    bl_mode = 3'd0;
    drive(C_WR, 2'd3, 8'h55, 1'b1, 32'h5555_0000, 4'h0);
    expect_beat("R10 bl1 precharge", 2'd3, 8'h55, 32'h5555_0000, 4'hF, 1'b1, 2'd3);
    drive(C_NOP, 2'd0, 8'h00, 1'b0, 32'h5555_0001, 4'h0);
    expect_idle("R3 bl1 ends");
  endtask

  task automatic t_deselect();
    bl_mode = 3'd1;
    drive(C_WR, 2'd2, 8'h03, 1'b0, 32'h6666_0000, 4'h0);
    expect_beat("R2 bl2 start", 2'd2, 8'h03, 32'h6666_0000, 4'hF, 1'b0, 2'd0);
    drive(C_DES, 2'd0, 8'h00, 1'b0, 32'h6666_0001, 4'h0);
    expect_beat("R12 deselect continues", 2'd2, 8'h02, 32'h6666_0001, 4'hF, 1'b0, 2'd0);
    drive(C_NOP, 2'd0, 8'h00, 1'b0, 32'h6666_0002, 4'h0);
    expect_idle("R3 bl2 ends");
  endtask

  initial begin
    rst_n = 1'b0;
    bl_mode = 3'd0;
    {cs_n, ras_n, cas_n, we_n} = C_NOP;
    ba = '0; addr = '0; ap_flag = 1'b0; dq = '0; dqm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_bl4_wrap();
    t_bl8_autopre();
    t_full_page();
    t_write_interrupt();
    t_mask_precharge();
    t_autopre_cut();
    t_deselect();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule